// File: doc/BRIEF.md
# Shift and Rotate Execution Unit with Condition Code

This unit carries out the single-operand shift and rotate operations of a register-based processor. A request carries a 64-bit operand, an operation code, a width code and the ingredients of the shift amount: the number of the base register, the value read from that register, and a signed displacement. The unit forms a six-bit shift amount, shifts or rotates the operand at the selected width, and returns the result. For the arithmetic shifts it also returns a 2-bit condition code, with a flag that tells the core whether the condition code is to be written.

The amount is always six bits wide, so a 32-bit operand can be shifted by up to 63 positions. A 32-bit logical shift by 32 or more therefore clears the value and does not leave it unchanged. Arithmetic left shifts never touch the sign bit and report lost significant bits as overflow. An even/odd pair of 32-bit registers is presented as one 64-bit operand, with the even register in the upper half, and is treated exactly like a 64-bit operand.

Requests use a valid/ready handshake. Each accepted request produces one registered response on the next clock edge.

Top module: `shift_rot_unit`

## Requirements
- R1: The shift amount is the low 6 bits of the displacement when the base register number is zero. Otherwise it is the low 6 bits of the base value plus the displacement, and the base value is ignored only in the first case.
- R2: Width codes are 0 for 32 bits, 1 for 64 bits and 2 for a register pair. A 32-bit logical shift (op 0 left, op 1 right) uses all 6 amount bits, so amounts 32 to 63 give zero. For every 32-bit operation, result bits 63:32 are zero and operand bits 63:32 are ignored.
- R3: Arithmetic left shift (op 2) copies the operand sign bit (bit 31 at 32-bit width, bit 63 otherwise) unchanged into the result. The bits below it are shifted left, with zeros entering at the bottom.
- R4: Arithmetic left shift returns condition code 3 when any operand bit shifted into or through the sign position differs from the sign bit.
- R5: Without overflow, arithmetic left shift returns condition code 0 for a zero result, 1 for a negative result and 2 for a positive result, with cc_upd set.
- R6: For a 32-bit arithmetic left shift, overflow is judged as if the operand sat in bits 63:32 of a 64-bit word with zeros below. An amount of 32 or more therefore overflows for any negative operand and for any nonzero positive operand.
- R7: Arithmetic right shift (op 3) fills vacated bits with the sign bit, and an amount at or beyond the width gives all sign copies. Its condition code is 0, 1 or 2 from the result at the selected width, never 3, with cc_upd set.
- R8: Width code 2 (register pair) gives the same result and condition code as width code 1 for every operation.
- R9: Rotate left (op 4) rotates a 64-bit operand by the amount and a 32-bit operand by the amount modulo 32. It clears cc_upd and drives a condition code of 0.
- R10: Logical shifts (op 0 and 1) clear cc_upd and drive a condition code of 0.
- R11: req_ready is low during reset and high otherwise. A response appears with rsp_valid high exactly one clock after each accepted request and never otherwise. Reset clears rsp_valid, rsp_result, rsp_cc and rsp_cc_upd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_op | input | 3 | Operation: 0 logical left, 1 logical right, 2 arithmetic left, 3 arithmetic right, 4 rotate left |
| req_width | input | 2 | 0 = 32-bit, 1 = 64-bit, 2 = even/odd register pair |
| req_operand | input | 64 | Operand (pair: even register in bits 63:32) |
| req_base_reg | input | 4 | Base register number; zero means no base |
| req_base_val | input | 64 | Contents of the base register |
| req_disp | input | 20 | Signed displacement |
| rsp_valid | output | 1 | Response present |
| rsp_result | output | 64 | Shifted or rotated value |
| rsp_cc | output | 2 | Condition code |
| rsp_cc_upd | output | 1 | Condition code is to be written |

## Verification
The bound properties take the request fields to be valid only in the cycle they are accepted and read them back through a one-cycle delay. This relies on every response following its request by exactly one edge. They also assume the operation code is one of the five defined values and the width code is 0, 1 or 2. The bench keeps to these by driving only defined codes, changing inputs on the falling edge, and sending requests both back to back and with idle gaps. It places its directed operands where the amount crosses 31, 32 and 63 and where the sign bit of an arithmetic left shift is or is not disturbed.

// File: rtl/sru_pkg.sv
package sru_pkg;

    localparam int unsigned XLEN  = 64;
    localparam int unsigned HLEN  = XLEN / 2;
    localparam int unsigned AMT_W = $clog2(XLEN);

    typedef enum logic [2:0] {
        OP_SLL = 3'd0,
        OP_SRL = 3'd1,
        OP_SLA = 3'd2,
        OP_SRA = 3'd3,
        OP_RLL = 3'd4
    } sr_op_e;

    typedef enum logic [1:0] {
        WD_32   = 2'd0,
        WD_64   = 2'd1,
        WD_PAIR = 2'd2
    } sr_width_e;

    typedef struct packed {
        logic [XLEN-1:0] value;
        logic [1:0]      cc;
        logic            cc_upd;
    } sr_resp_t;

    function automatic logic is_narrow(input logic [1:0] w);
        return w == WD_32;
    endfunction

    // Condition code of a signed value: 0 zero, 1 negative, 2 positive.
    function automatic logic [1:0] sign_cc(input logic [XLEN-1:0] v);
        if (v == '0)
            return 2'd0;
        else if (v[XLEN-1])
            return 2'd1;
        else
            return 2'd2;
    endfunction

endpackage

// File: rtl/sru_amount.sv
module sru_amount #(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned DISP_W = 20,
    parameter int unsigned BREG_W = 4,
    localparam int unsigned AMT_W = $clog2(DATA_W)
) (
    input  logic [BREG_W-1:0] base_reg,
    input  logic [DATA_W-1:0] base_val,
    input  logic [DISP_W-1:0] disp,
    output logic [AMT_W-1:0]  amount
);
    logic [DATA_W-1:0] disp_ext;
    logic [DATA_W-1:0] eff_addr;

    assign disp_ext = {{(DATA_W-DISP_W){disp[DISP_W-1]}}, disp};

    always_comb begin
        if (base_reg == '0)
            eff_addr = disp_ext;
        else
            eff_addr = base_val + disp_ext;
        amount = eff_addr[AMT_W-1:0];
    end
endmodule

// File: rtl/sru_shift_core.sv
module sru_shift_core
    import sru_pkg::*;
(
    input  logic [2:0]       op,
    input  logic             narrow,
    input  logic [XLEN-1:0]  operand,
    input  logic [AMT_W-1:0] amount,
    output logic [XLEN-1:0]  result,
    output logic [XLEN-1:0]  cc_view,
    output logic             sla_ovf
);
    localparam logic [AMT_W:0] TOP_IDX = AMT_W'(XLEN - 1);

    logic [XLEN-1:0]   lo_zext;
    logic [XLEN-1:0]   lo_sext;
    logic [XLEN-1:0]   sll_full;
    logic [XLEN-1:0]   srl_full;
    logic [XLEN-1:0]   sra_full;
    logic [XLEN-1:0]   sla_src;
    logic [XLEN-1:0]   sla_shl;
    logic [XLEN-1:0]   sla_word;
    logic [XLEN-1:0]   ovf_mask;
    logic [2*XLEN-1:0] rot_wide;
    logic [XLEN-1:0]   rot_narrow;
    logic [XLEN-1:0]   sra_res;

    assign lo_zext = {{HLEN{1'b0}}, operand[HLEN-1:0]};
    assign lo_sext = {{HLEN{operand[HLEN-1]}}, operand[HLEN-1:0]};

    assign sll_full = (narrow ? lo_zext : operand) << amount;
    assign srl_full = (narrow ? lo_zext : operand) >> amount;
    assign sra_full = $unsigned($signed(narrow ? lo_sext : operand) >>> amount);

    // Arithmetic left works on a 64-bit word; a narrow operand sits on top.
    assign sla_src  = narrow ? {operand[HLEN-1:0], {HLEN{1'b0}}} : operand;
    assign sla_shl  = sla_src << amount;
    assign sla_word = {sla_src[XLEN-1], sla_shl[XLEN-2:0]};
    assign ovf_mask = {XLEN{1'b1}} << (TOP_IDX - {1'b0, amount});
    assign sla_ovf  = |((sla_src ^ {XLEN{sla_src[XLEN-1]}}) & ovf_mask);

    assign rot_wide = {operand, operand} << amount;
    always_comb begin
        logic [XLEN-1:0] pair32;
        pair32     = {operand[HLEN-1:0], operand[HLEN-1:0]} << amount[AMT_W-2:0];
        rot_narrow = {{HLEN{1'b0}}, pair32[XLEN-1:HLEN]};
    end

    assign sra_res = narrow ? {{HLEN{1'b0}}, sra_full[HLEN-1:0]} : sra_full;

    always_comb begin
        cc_view = '0;
        unique case (op)
            OP_SLL:  result = narrow ? {{HLEN{1'b0}}, sll_full[HLEN-1:0]} : sll_full;
            OP_SRL:  result = srl_full;
            OP_SLA: begin
                result  = narrow ? {{HLEN{1'b0}}, sla_word[XLEN-1:HLEN]} : sla_word;
                cc_view = sla_word;
            end
            OP_SRA: begin
                result  = sra_res;
                cc_view = narrow ? {sra_res[HLEN-1:0], {HLEN{1'b0}}} : sra_res;
            end
            OP_RLL:  result = narrow ? rot_narrow : rot_wide[2*XLEN-1:XLEN];
            default: result = narrow ? lo_zext : operand;
        endcase
    end
endmodule

// File: rtl/sru_ccgen.sv
module sru_ccgen
    import sru_pkg::*;
(
    input  logic [2:0]      op,
    input  logic [XLEN-1:0] cc_view,
    input  logic            sla_ovf,
    output logic [1:0]      cc,
    output logic            cc_upd
);
    always_comb begin
        cc     = 2'd0;
        cc_upd = 1'b0;
        if (op == OP_SLA) begin
            cc_upd = 1'b1;
            cc     = sla_ovf ? 2'd3 : sign_cc(cc_view);
        end else if (op == OP_SRA) begin
            cc_upd = 1'b1;
            cc     = sign_cc(cc_view);
        end
    end
endmodule

// File: rtl/shift_rot_unit.sv
module shift_rot_unit
    import sru_pkg::*;
#(
    parameter int unsigned DISP_W = 20,
    parameter int unsigned BREG_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_op,
    input  logic [1:0]        req_width,
    input  logic [XLEN-1:0]   req_operand,
    input  logic [BREG_W-1:0] req_base_reg,
    input  logic [XLEN-1:0]   req_base_val,
    input  logic [DISP_W-1:0] req_disp,
    output logic              rsp_valid,
    output logic [XLEN-1:0]   rsp_result,
    output logic [1:0]        rsp_cc,
    output logic              rsp_cc_upd
);
    logic [AMT_W-1:0] amount;
    logic [XLEN-1:0]  core_result;
    logic [XLEN-1:0]  cc_view;
    logic             sla_ovf;
    sr_resp_t         next_resp;
    sr_resp_t         resp_q;
    logic             accept;

    assign req_ready = ~rst;
    assign accept    = req_valid & req_ready;

    sru_amount #(
        .DATA_W (XLEN),
        .DISP_W (DISP_W),
        .BREG_W (BREG_W)
    ) amount_i (
        .base_reg (req_base_reg),
        .base_val (req_base_val),
        .disp     (req_disp),
        .amount   (amount)
    );

    sru_shift_core core_i (
        .op      (req_op),
        .narrow  (is_narrow(req_width)),
        .operand (req_operand),
        .amount  (amount),
        .result  (core_result),
        .cc_view (cc_view),
        .sla_ovf (sla_ovf)
    );

    sru_ccgen ccgen_i (
        .op      (req_op),
        .cc_view (cc_view),
        .sla_ovf (sla_ovf),
        .cc      (next_resp.cc),
        .cc_upd  (next_resp.cc_upd)
    );

    assign next_resp.value = core_result;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            resp_q    <= '0;
        end else begin
            rsp_valid <= accept;
            if (accept)
                resp_q <= next_resp;
        end
    end

    assign rsp_result = resp_q.value;
    assign rsp_cc     = resp_q.cc;
    assign rsp_cc_upd = resp_q.cc_upd;
endmodule

// File: rtl/sru_checker.sv
module sru_checker
    import sru_pkg::*;
#(
    parameter int unsigned DISP_W = 20,
    parameter int unsigned BREG_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic [2:0]        req_op,
    input logic [1:0]        req_width,
    input logic [XLEN-1:0]   req_operand,
    input logic [BREG_W-1:0] req_base_reg,
    input logic [XLEN-1:0]   req_base_val,
    input logic [DISP_W-1:0] req_disp,
    input logic              rsp_valid,
    input logic [XLEN-1:0]   rsp_result,
    input logic [1:0]        rsp_cc,
    input logic              rsp_cc_upd
);
    AST_ACCEPT_RESPONDS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> rsp_valid);  // R11
    AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_ready) |=> !rsp_valid);  // R11
    AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && $past(req_width) == WD_32) |-> rsp_result[XLEN-1:HLEN] == '0);  // R2
    AST_SLA_SIGN_WIDE: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && $past(req_op) == OP_SLA && $past(req_width) != WD_32)
        |-> rsp_result[XLEN-1] == $past(req_operand[XLEN-1]));  // R3
    AST_SLA_SIGN_NARROW: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && $past(req_op) == OP_SLA && $past(req_width) == WD_32)
        |-> rsp_result[HLEN-1] == $past(req_operand[HLEN-1]));  // R3
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && $past(req_op) == OP_SRA) |-> (rsp_cc != 2'd3 && rsp_cc_upd));  // R7
    AST_SLA_UPDATES: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && $past(req_op) == OP_SLA) |-> rsp_cc_upd);  // R5
    AST_ROTATE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && $past(req_op) == OP_RLL) |-> (!rsp_cc_upd && rsp_cc == 2'd0));  // R9
    AST_LOGICAL_QUIET: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && ($past(req_op) == OP_SLL || $past(req_op) == OP_SRL))
        |-> (!rsp_cc_upd && rsp_cc == 2'd0));  // R10
endmodule

bind shift_rot_unit sru_checker #(.DISP_W(DISP_W), .BREG_W(BREG_W)) chk_i (.*);

// File: tb/shift_rot_unit_tb_top.sv
module shift_rot_unit_tb_top;

    typedef struct {
        logic [63:0] value;
        logic [1:0]  cc;
        logic        upd;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_op = '0;
    logic [1:0]  req_width = '0;
    logic [63:0] req_operand = '0;
    logic [3:0]  req_base_reg = '0;
    logic [63:0] req_base_val = '0;
    logic [19:0] req_disp = '0;
    logic        rsp_valid;
    logic [63:0] rsp_result;
    logic [1:0]  rsp_cc;
    logic        rsp_cc_upd;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    shift_rot_unit dut_i (
        .clk (clk), .rst (rst),
        .req_valid (req_valid), .req_ready (req_ready),
        .req_op (req_op), .req_width (req_width), .req_operand (req_operand),
        .req_base_reg (req_base_reg), .req_base_val (req_base_val), .req_disp (req_disp),
        .rsp_valid (rsp_valid), .rsp_result (rsp_result),
        .rsp_cc (rsp_cc), .rsp_cc_upd (rsp_cc_upd)
    );

    function automatic void ref_model(input logic [2:0] op, input logic [1:0] w,
                                      input logic [63:0] x, input int n,
                                      output logic [63:0] r, output logic [1:0] cc,
                                      output logic upd);
        int W;
        int k;
        logic [63:0] xs;
        logic [63:0] t;
        logic ovf;
        W = (w == 2'd0) ? 32 : 64;
        xs = (W == 32) ? {32'b0, x[31:0]} : x;
        r = '0; cc = 2'd0; upd = 1'b0;
        case (op)
            3'd0: for (int i = 0; i < W; i++) r[i] = (i >= n) ? xs[i-n] : 1'b0;
            3'd1: for (int i = 0; i < W; i++) r[i] = (i + n < W) ? xs[i+n] : 1'b0;
            3'd2: begin
                upd = 1'b1;
                for (int i = 0; i < W - 1; i++) r[i] = (i >= n) ? xs[i-n] : 1'b0;
                r[W-1] = xs[W-1];
                t = (W == 32) ? {x[31:0], 32'b0} : x;
                ovf = 1'b0;
                for (int j = 63 - n; j <= 63; j++) if (t[j] != t[63]) ovf = 1'b1;
                if (ovf) cc = 2'd3;
                else cc = (r == 0) ? 2'd0 : (r[W-1] ? 2'd1 : 2'd2);
            end
            3'd3: begin
                upd = 1'b1;
                for (int i = 0; i < W; i++) r[i] = (i + n < W) ? xs[i+n] : xs[W-1];
                cc = (r == 0) ? 2'd0 : (r[W-1] ? 2'd1 : 2'd2);
            end
            3'd4: begin
                k = (W == 32) ? n % 32 : n;
                for (int i = 0; i < W; i++) r[i] = xs[(i - k + W) % W];
            end
            default: r = xs;
        endcase
    endfunction

    // Driver: one request per call, leaves valid high for back-to-back use.
    task automatic send(input logic [2:0] op, input logic [1:0] w, input logic [63:0] x,
                        input logic [3:0] breg, input logic [63:0] bval,
                        input logic [19:0] disp, input string tag);
        exp_t e;
        logic [63:0] bsum;
        int amt;
        bsum = bval + {{44{disp[19]}}, disp};
        amt = (breg == 4'd0) ? int'(disp[5:0]) : int'(bsum[5:0]);
        ref_model(op, w, x, amt, e.value, e.cc, e.upd);
        e.tag = tag;
        sb_q.push_back(e);
        req_valid = 1'b1; req_op = op; req_width = w; req_operand = x;
        req_base_reg = breg; req_base_val = bval; req_disp = disp;
        @(negedge clk);
    endtask

    task automatic idle_check();
        req_valid = 1'b0;
        req_operand = 64'hFFFF_0000_FFFF_0000;
        @(negedge clk);
        @(negedge clk);
        n_cmp++;
        if (rsp_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R11 idle rsp_valid act=%b exp=0", rsp_valid);
        end
    endtask

    // Monitor: pops the scoreboard on each response.
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            n_cmp++;
            if (sb_q.size() == 0) begin
                n_bad++;
                $display("FAIL R11 unexpected response act=%h exp=none", rsp_result);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                if (rsp_result !== e.value || rsp_cc !== e.cc || rsp_cc_upd !== e.upd) begin
                    n_bad++;
                    $display("FAIL %s act=%h/cc%0d/u%b exp=%h/cc%0d/u%b", e.tag,
                             rsp_result, rsp_cc, rsp_cc_upd, e.value, e.cc, e.upd);
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog act=running exp=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        n_cmp++;  // R11 reset state
        if (rsp_valid !== 1'b0 || rsp_result !== 64'd0 || rsp_cc !== 2'd0 ||
            rsp_cc_upd !== 1'b0 || req_ready !== 1'b0) begin
            n_bad++;
            $display("FAIL R11 reset act=%b/%h/%0d/%b/%b exp=0/0/0/0/0",
                     rsp_valid, rsp_result, rsp_cc, rsp_cc_upd, req_ready);
        end
        rst = 1'b0;
        @(negedge clk);
        n_cmp++;
        if (req_ready !== 1'b1) begin
            n_bad++;
            $display("FAIL R11 ready act=%b exp=1", req_ready);
        end

        // R1: amount sources
        send(3'd0, 2'd1, 64'd1, 4'd0, 64'hFFFF, 20'h00045, "R1 disp only");
        send(3'd0, 2'd1, 64'd1, 4'd3, 64'h3E, 20'h00003, "R1 base+disp");
        send(3'd1, 2'd1, 64'h8000_0000_0000_0000, 4'd7, 64'h100, 20'hFFFFF, "R1 neg disp");
        idle_check();
        // R2: narrow logical shifts use six amount bits
        send(3'd1, 2'd0, 64'h0000_0000_FFFF_FFFF, 4'd0, 64'd0, 20'd32, "R2 srl32 by 32");
        send(3'd0, 2'd0, 64'hDEAD_BEEF_0000_0001, 4'd0, 64'd0, 20'd40, "R2 sll32 by 40");
        send(3'd0, 2'd0, 64'hDEAD_BEEF_0000_0001, 4'd0, 64'd0, 20'd31, "R2 sll32 by 31");
        send(3'd1, 2'd0, 64'hFFFF_FFFF_8000_0000, 4'd0, 64'd0, 20'd31, "R2 srl32 by 31");
        // R3 R4 R5: wide arithmetic left
        send(3'd2, 2'd1, 64'd3, 4'd0, 64'd0, 20'd4, "R5 sla pos");
        send(3'd2, 2'd1, 64'hFFFF_FFFF_FFFF_FFF0, 4'd0, 64'd0, 20'd4, "R5 sla neg");
        send(3'd2, 2'd1, 64'h4000_0000_0000_0000, 4'd0, 64'd0, 20'd1, "R4 sla ovf");
        send(3'd2, 2'd1, 64'd0, 4'd0, 64'd0, 20'd63, "R5 sla zero");
        send(3'd2, 2'd1, 64'h8000_0000_0000_0000, 4'd0, 64'd0, 20'd0, "R3 sla sign kept");
        send(3'd2, 2'd1, 64'hC000_0000_0000_0001, 4'd0, 64'd0, 20'd1, "R3 sla neg shift");
        // R6: narrow arithmetic left
        send(3'd2, 2'd0, 64'h0000_0000_4000_0000, 4'd0, 64'd0, 20'd1, "R6 sla32 ovf");
        send(3'd2, 2'd0, 64'h0000_0000_0000_0001, 4'd0, 64'd0, 20'd32, "R6 sla32 by 32");
        send(3'd2, 2'd0, 64'h0000_0000_8000_0000, 4'd0, 64'd0, 20'd40, "R6 sla32 neg big");
        send(3'd2, 2'd0, 64'hFFFF_FFFF_0000_0000, 4'd0, 64'd0, 20'd50, "R6 sla32 zero");
        send(3'd2, 2'd0, 64'h0000_0000_0000_1234, 4'd0, 64'd0, 20'd8, "R6 sla32 pos");
        idle_check();
        // R7: arithmetic right
        send(3'd3, 2'd0, 64'h0000_0000_8000_0000, 4'd0, 64'd0, 20'd63, "R7 sra32 fill");
        send(3'd3, 2'd1, 64'h7FFF_0000_0000_0000, 4'd0, 64'd0, 20'd63, "R7 sra64 zero");
        send(3'd3, 2'd1, 64'hF000_0000_0000_0000, 4'd0, 64'd0, 20'd4, "R7 sra64 neg");
        send(3'd3, 2'd0, 64'h8000_0000_4000_0000, 4'd0, 64'd0, 20'd2, "R7 sra32 pos");
        // R8: register pair
        send(3'd0, 2'd2, 64'h0000_0001_8000_0000, 4'd0, 64'd0, 20'd40, "R8 pair sll");
        send(3'd3, 2'd2, 64'h8000_0000_0000_0000, 4'd0, 64'd0, 20'd33, "R8 pair sra");
        send(3'd2, 2'd2, 64'h0000_0001_0000_0000, 4'd0, 64'd0, 20'd31, "R8 pair sla");
        // R9: rotate
        send(3'd4, 2'd0, 64'hAAAA_AAAA_8000_0001, 4'd0, 64'd0, 20'd33, "R9 rll32 mod");
        send(3'd4, 2'd1, 64'h8000_0000_0000_0001, 4'd0, 64'd0, 20'd63, "R9 rll64");
        send(3'd4, 2'd1, 64'h1234_5678_9ABC_DEF0, 4'd0, 64'd0, 20'd0, "R9 rll64 zero amt");
        // R10: logical leaves cc alone
        send(3'd1, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF, 4'd0, 64'd0, 20'd1, "R10 srl64");
        idle_check();

        for (int i = 0; i < 600; i++) begin
            logic [2:0] op;
            logic [1:0] w;
            string tg;
            op = 3'($urandom_range(0, 4));
            w = 2'($urandom_range(0, 2));
            case (op)
                3'd2: tg = "R4 rand sla";
                3'd3: tg = "R7 rand sra";
                3'd4: tg = "R9 rand rll";
                default: tg = "R10 rand logical";
            endcase
            if (w == 2'd2) tg = {"R8 ", tg};
            send(op, w, {$urandom, $urandom}, 4'($urandom_range(0, 3)),
                 {$urandom, $urandom}, 20'($urandom), tg);
            if ($urandom_range(0, 3) == 0) idle_check();
        end
        idle_check();
        n_cmp++;
        if (sb_q.size() != 0) begin
            n_bad++;
            $display("FAIL R11 missing responses act=%0d exp=0", sb_q.size());
        end
        finish_run();
    end
endmodule